// File: doc/BRIEF.md
# MDIO Management Master

This block is a management master for the two-wire serial management bus used to configure Ethernet PHYs. Software programs it through a small 32-bit register bus. It then produces the management clock and shifts a complete frame onto the data line. On a read it releases the line and captures the 16-bit value the PHY returns. One register set serves both the Clause 22 and the Clause 45 framing. A mode bit picks the clause, and the meaning of each command code depends on that bit.

The software sequence is as follows. Set the clause bit in the mode register with a read-modify-write. Load the PHY address and the register or device number. Load the write-data register. Then write the command register with the start bit set and an access code. A busy flag stays up until the last bit has left the wire, and software polls it before issuing the next command. A Clause 45 read takes two commands. The first sends an address frame that carries the write-data register as the 16-bit register address. The second sends the read frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, mdc is low, mdio_oe is low, the busy bit reads 0, and the mode, address, write-data, read-data and command registers read 0.
- R2: Register offsets are 0x40 mode, 0x44 address, 0x48 write data, 0x4C read data and 0x50 command. The mode register keeps all 32 written bits, so flipping bit 8 leaves the other bits unchanged. The address register holds the PHY address in bits 12:8 and the register or device number in bits 4:0, and reads 0 elsewhere. Write data keeps bits 15:0 only.
- R3: While busy, mdc has a period of CLK_DIV system clocks. It is low whenever the block is idle. A frame lasts exactly 64 mdc periods, so the busy bit clears exactly 64*CLK_DIV clocks after the edge that accepted the command.
- R4: Every frame begins with 32 ones. The remaining 32 bits follow MSB first: start, opcode, PHY address, register or device number, turnaround, data. mdio_o changes only when mdc falls, so it is stable while mdc is high.
- R5: With mode bit 8 clear, the frame uses start 01. Code 0 is a read with opcode 10. Code 1 is a write with opcode 01, turnaround 10 and the write-data register as data.
- R6: With mode bit 8 set, the frame uses start 00 and carries the device number in the register field. Code 0 is an address frame with opcode 00 and the write-data register as data. Code 1 is a write with opcode 01. Code 2 is a read with opcode 11. Address and write frames drive turnaround 10.
- R7: In a read frame, mdio_oe drops for the two turnaround bits and the 16 data bits. Data bits are sampled on rising mdc edges, MSB first. The read-data register bits 15:0 take the captured value when the frame completes and hold steady while the frame runs.
- R8: An accepted command sets the busy bit (command register bit 16) from the next cycle. A command write that arrives while busy is set is ignored: it starts no frame and leaves the stored code (command bits 1:0) unchanged. This includes a write in the very cycle the frame ends.
- R9: Undefined codes are ignored, and busy stays clear. These are codes 2 and 3 with bit 8 of the mode register clear, and code 3 with it set. The code is taken from command bits 1:0.
- R10: A command register write with bit 8 clear starts nothing.
- R11: mdio_oe is low whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable; low means released |
| mdio_i | input | 1 | Data line as seen on the pin |

## Verification
Two events can land on the same clock edge: the end of a frame, which clears busy, and a new command write. The bench times a command write so that it is sampled on the exact edge at which the frame finishes. It expects that write to be dropped. After the edge, busy must read clear, mdc must stay low and the stored code must be unchanged. A second command written mid-frame must not shift the completion time away from 64*CLK_DIV clocks.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int CLK_DIV = 64,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(HALF);
  localparam logic [AW-1:0] A_MODE = AW'(8'h40);
  localparam logic [AW-1:0] A_ADDR = AW'(8'h44);
  localparam logic [AW-1:0] A_WDAT = AW'(8'h48);
  localparam logic [AW-1:0] A_RDAT = AW'(8'h4C);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h50);

  logic [31:0]   mode_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   wd_q, rd_q, cap_q;
  logic [1:0]    code_q;
  logic          busy, rd_op;
  logic [5:0]    bitn;
  logic [31:0]   frm;
  logic [CW-1:0] cnt;
  logic [1:0]    op;

  wire       c45     = mode_q[8];
  wire [1:0] nc      = bus_wdata[1:0];
  wire       code_ok = c45 ? (nc != 2'd3) : !nc[1];
  wire       go      = bus_wr && bus_addr == A_CMD && bus_wdata[8] && !busy && code_ok;
  wire       nxt_rd  = c45 ? (nc == 2'd2) : (nc == 2'd0);
  wire       tick    = busy && cnt == CW'(HALF - 1);
  wire       rise    = tick && !mdc;
  wire       fall    = tick && mdc;

  always_comb begin
    if (c45) op = (nc == 2'd0) ? 2'b00 : (nc == 2'd1) ? 2'b01 : 2'b11;
    else     op = (nc == 2'd0) ? 2'b10 : 2'b01;
  end

  assign mdio_oe = busy && !(rd_op && bitn >= 6'd46);
  assign mdio_o  = mdio_oe && (bitn[5] ? frm[31] : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      phy_q  <= '0;
      reg_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      cap_q  <= '0;
      code_q <= '0;
      busy   <= 1'b0;
      rd_op  <= 1'b0;
      bitn   <= '0;
      frm    <= '0;
      cnt    <= '0;
      mdc    <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_MODE: mode_q <= bus_wdata;
          A_ADDR: begin
            phy_q <= bus_wdata[12:8];
            reg_q <= bus_wdata[4:0];
          end
          A_WDAT: wd_q <= bus_wdata[15:0];
          default: ;
        endcase
      end
      if (go) begin
        busy   <= 1'b1;
        code_q <= nc;
        rd_op  <= nxt_rd;
        bitn   <= '0;
        cnt    <= '0;
        mdc    <= 1'b0;
        frm    <= {(c45 ? 2'b00 : 2'b01), op, phy_q, reg_q, 2'b10, wd_q};
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (rise) begin
          mdc <= 1'b1;
          if (rd_op && bitn >= 6'd48) cap_q <= {cap_q[14:0], mdio_i};
        end
        if (fall) begin
          mdc <= 1'b0;
          if (bitn == 6'd63) begin
            busy <= 1'b0;
            if (rd_op) rd_q <= cap_q;
          end else begin
            bitn <= bitn + 1'b1;
            if (bitn[5]) frm <= frm << 1;
          end
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_ADDR:  bus_rdata = {19'd0, phy_q, 3'd0, reg_q};
      A_WDAT:  bus_rdata = {16'd0, wd_q};
      A_RDAT:  bus_rdata = {16'd0, rd_q};
      A_CMD:   bus_rdata = {15'd0, busy, 14'd0, code_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    code_q,
  input logic [15:0]   rd_q
);
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_idle_mdc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_hold_while_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  assert_busy_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == AW'(8'h50)) |=> $stable(code_q));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_q));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .code_q(code_q), .rd_q(rd_q)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int DIV = 8;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_oe = 0, phy_val = 0;
  int          total = 0, bad = 0;
  int          cyc = 0;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  mdio_mgmt_master #(.CLK_DIV(DIV), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_clause(input bit c45);
    logic [31:0] d;
    @(negedge clk);
    rd(8'h40, d);
    d[8] = c45;
    wr(8'h40, d);
  endtask

  function automatic logic [63:0] exp_frame(input bit c45, input logic [1:0] code,
      input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] wd, input logic [15:0] rdv);
    logic [1:0] st, op;
    bit rdf;
    st  = c45 ? 2'b00 : 2'b01;
    if (c45) op = (code == 0) ? 2'b00 : (code == 1) ? 2'b01 : 2'b11;
    else     op = (code == 0) ? 2'b10 : 2'b01;
    rdf = c45 ? (code == 2) : (code == 0);
    return {32'hFFFF_FFFF, st, op, phy, rn, 2'b10, rdf ? rdv : wd};
  endfunction

  task automatic run_frame(input bit c45, input logic [1:0] code, input logic [4:0] phy,
      input logic [4:0] rn, input logic [15:0] wd, input logic [15:0] rdv, input string req);
    logic [63:0] cap;
    logic [31:0] d;
    int t0, polls;
    bit rdf;
    rdf = c45 ? (code == 2) : (code == 0);
    wr(8'h44, {19'd0, phy, 3'd0, rn});
    wr(8'h48, {16'd0, wd});
    wr(8'h50, {23'd0, 1'b1, 6'd0, code});
    t0 = cyc;
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc);
      #1 cap[63-i] = mdio_i;
      if (rdf && i >= 46 && i < 63) begin
        @(negedge mdc);
        phy_oe  = 1;
        phy_val = (i == 46) ? 1'b0 : rdv[62-i];
      end
    end
    if (rdf) begin
      @(negedge mdc);
      phy_oe = 0;
    end
    polls = 0;
    do begin
      @(negedge clk);
      rd(8'h50, d);
      polls++;
    end while (d[16] && polls < 4 * DIV);
    check({req, " R3 frame length"}, 64'(cyc - t0), 64'(64 * DIV));
    check({req, " R4 frame bits"}, cap, exp_frame(c45, code, phy, rn, wd, rdv));
    check("R11 released when idle", {63'd0, mdio_oe}, 64'd0);
    if (rdf) begin
      rd(8'h4C, d);
      check("R7 read data", {32'd0, d}, {48'd0, rdv});
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(8'h40, d); check("R1 mode reset", {32'd0, d}, 64'd0);
    rd(8'h44, d); check("R1 addr reset", {32'd0, d}, 64'd0);
    rd(8'h4C, d); check("R1 rdata reset", {32'd0, d}, 64'd0);
    rd(8'h50, d); check("R1 cmd reset", {32'd0, d}, 64'd0);
    check("R1 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);

    wr(8'h40, 32'hA5A5_5A5A);
    set_clause(1);
    @(negedge clk); rd(8'h40, d); check("R2 mode set bit8", {32'd0, d}, {32'd0, 32'hA5A5_5B5A});
    set_clause(0);
    @(negedge clk); rd(8'h40, d); check("R2 mode clear bit8", {32'd0, d}, {32'd0, 32'hA5A5_5A5A});
    wr(8'h44, 32'hFFFF_FFFF);
    @(negedge clk); rd(8'h44, d); check("R2 addr fields", {32'd0, d}, 64'h0000_1F1F);
    wr(8'h48, 32'h1234_5678);
    @(negedge clk); rd(8'h48, d); check("R2 wdata width", {32'd0, d}, 64'h5678);

    wr(8'h50, 32'h0000_0001);
    @(negedge clk); rd(8'h50, d); check("R10 no start bit", {63'd0, d[16]}, 64'd0);
    wr(8'h50, 32'h0000_0102);
    @(negedge clk); rd(8'h50, d); check("R9 C22 code 2", {63'd0, d[16]}, 64'd0);
    wr(8'h50, 32'h0000_0103);
    @(negedge clk); rd(8'h50, d); check("R9 C22 code 3", {63'd0, d[16]}, 64'd0);
    check("R9 line idle", {62'd0, mdc, mdio_oe}, 64'd0);

    run_frame(0, 2'd1, 5'h11, 5'h0A, 16'hBEEF, 16'h0000, "R5 c22 write");
    run_frame(0, 2'd0, 5'h03, 5'h1F, 16'h0000, 16'hC3A5, "R5 c22 read");

    set_clause(1);
    wr(8'h50, 32'h0000_0103);
    @(negedge clk); rd(8'h50, d); check("R9 C45 code 3", {63'd0, d[16]}, 64'd0);
    run_frame(1, 2'd0, 5'h1C, 5'h07, 16'h8001, 16'h0000, "R6 c45 address");
    run_frame(1, 2'd2, 5'h1C, 5'h07, 16'h8001, 16'h7E18, "R6 c45 read");
    run_frame(1, 2'd1, 5'h02, 5'h01, 16'h0F0F, 16'h0000, "R6 c45 write");

    set_clause(0);
    wr(8'h44, 32'h0000_0505);
    wr(8'h50, 32'h0000_0101);
    t0 = cyc;
    rd(8'h50, d); check("R8 busy after start", {63'd0, d[16]}, 64'd1);
    repeat (5 * DIV) @(negedge clk);
    wr(8'h50, 32'h0000_0100);
    while (cyc < t0 + 64 * DIV - 1) @(negedge clk);
    bus_wr = 1; bus_addr = 8'h50; bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_wr = 0;
    check("R8 end edge", 64'(cyc - t0), 64'(64 * DIV));
    rd(8'h50, d);
    check("R8 same-cycle cmd dropped", {32'd0, d}, 64'h1);
    repeat (2 * DIV) @(negedge clk);
    rd(8'h50, d);
    check("R8 still idle", {63'd0, d[16]}, 64'd0);
    check("R3 mdc idle low", {63'd0, mdc}, 64'd0);

    for (int k = 0; k < 16; k++) begin
      bit c45;
      logic [1:0] code;
      c45  = 1'($urandom);
      code = c45 ? 2'($urandom % 3) : 2'($urandom % 2);
      set_clause(c45);
      run_frame(c45, code, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                c45 ? "R6 random" : "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule